// File: doc/BRIEF.md
# Machine Status Register with Summary-Dirty Tracking

This block holds the machine-level status word of a RISC-V style hart and offers a narrower supervisor view of the same storage. A CSR access port writes a full-width value through either the machine address or the supervisor address. Only the fields that are writable for the selected privilege-spec generation are updated. After every update the summary-dirty bit is rebuilt from the floating-point and extension state fields. A translation-flush pulse lasting one cycle goes out whenever a write changes a field that address translation depends on.

The register width is 32 or 64 bits (parameter `XLEN`), and the reset value is a parameter. An input selects between the older and the newer field sets. A separate strobe from the floating-point side forces the floating-point state to dirty and updates the summary bit with it.

Top module: `msr_status_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the register equals the `RST_VAL` parameter (zero by default) and `tlbFlush` is low.
- R2: On a machine write in the newer set (`specNew`=1), bits 1, 3, 5, 7, 8, 12:11, 14:13 and 17..19 take the written value and all other bits keep their value, except the bit named in R6. Bit 0, bits 10:9 and the extension state in bits 16:15 are never changed by a write.
- R3: The trap-control bits 22:20 can be written only when `specNew`=1. With `specNew`=0 they hold their value.
- R4: With `XLEN`=64 and `specNew`=1, bits 39 and 38 can also be written. With `specNew`=0 they hold.
- R5: With `specNew`=0, the translation-mode field in bits 28:24 is written only if the merged value in that field is a supported mode: 0, or 8 when `XLEN`=32, or 9 or 10 when `XLEN`=64. Otherwise the field keeps its old value.
- R6: After every write or dirty strobe, the top bit is 1 exactly when bits 14:13 are 2'b11 or bits 16:15 are 2'b11, and 0 otherwise. The written value of the top bit is ignored.
- R7: In the cycle after a write, `tlbFlush` is high for exactly one cycle if the merged value differs from the old register in bits 19, 12:11, 17 or 18. The same holds for bit 39 when `XLEN`=64 and `specNew`=1, and for bits 28:24 when `specNew`=0. Otherwise `tlbFlush` is low.
- R8: `supViewOut` equals the register ANDed with the supervisor mask. The mask covers bits 0, 1, 4, 5, 8, 16:13, 18 and the top bit, plus bit 19 when `specNew`=1.
- R9: A write with `csrSupSel`=1 first merges the data into the current register under the supervisor mask. It then applies R2 to R7 to the merged word, so bits outside the supervisor mask, such as 3, 7 and 12:11, are unchanged.
- R10: `fpDirtySet` makes bits 14:13 equal 2'b11 and sets the top bit on the next cycle. If a write happens in the same cycle, the write is applied first.
- R11: With no write and no dirty strobe, the register holds its value and `tlbFlush` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | CSR write strobe |
| csrSupSel | input | 1 | 1 when the write targets the supervisor address |
| csrWrData | input | XLEN | Written value |
| specNew | input | 1 | 1 selects the newer field set, 0 the older |
| fpDirtySet | input | 1 | Marks floating-point state dirty |
| statusOut | output | XLEN | Full machine status word |
| supViewOut | output | XLEN | Supervisor view of the status word |
| tlbFlush | output | 1 | One-cycle translation flush request |

## Verification
The bench aims at the summary bit in both directions. Writing dirty and then clean floating-point state must set and then clear it. A design that only ever sets the bit would leave it high. A written top bit must not stick. A second instance whose reset leaves the extension field dirty checks that the summary bit stays high after the floating-point state is cleared.

Flush checks include the following cases:
- Writing the same value twice must not flush. A design that flushes on every write fails here.
- A change to the extension bit flushes only under the newer set. A design that ignores the spec select fails here.
- An unsupported translation mode still flushes but is not stored.

Supervisor writes of all ones must leave the machine-only fields alone. A design that skips the merge would corrupt the privilege field. A dirty strobe in the same cycle as a clearing write must win.

// File: rtl/msr_pkg.sv
package msr_pkg;

  // Field bit positions used by behaviour.
  localparam int FsLo = 13;
  localparam int XsLo = 15;
  localparam int VmLo = 24;
  localparam int VmW  = 5;

  // Writable in both generations: SIE, MIE, SPIE, MPIE, SPP, MPP, FS, MPRV, SUM, MXR.
  localparam logic [63:0] WrBase    = 64'h0000_0000_000E_79AA;
  // Trap-control bits (TVM, TW, TSR), newer generation only.
  localparam logic [63:0] WrTrapCtl = 64'h0000_0000_0070_0000;
  // Two extra bits present only on 64-bit harts.
  localparam logic [63:0] WrExt64   = 64'h0000_00C0_0000_0000;
  localparam logic [63:0] VmField   = 64'h0000_0000_1F00_0000;
  // Translation-related fields: MXR, MPP, MPRV, SUM.
  localparam logic [63:0] FlBase    = 64'h0000_0000_000E_1800;
  localparam logic [63:0] FlVirt64  = 64'h0000_0080_0000_0000;
  // Supervisor view without the summary bit.
  localparam logic [63:0] SupBase   = 64'h0000_0000_0005_E133;
  localparam logic [63:0] MxrBit    = 64'h0000_0000_0008_0000;

  typedef struct packed {
    logic doWrite;
    logic viaSup;
    logic markFp;
  } msrStrobe_t;

endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csrWrEn,
  input  logic       csrSupSel,
  input  logic       fpDirtySet,
  input  logic       diffHit,
  output msrStrobe_t strb,
  output logic       flushPulse
);

  always_comb begin
    strb.doWrite = csrWrEn;
    strb.viaSup  = csrWrEn & csrSupSel;
    strb.markFp  = fpDirtySet;
  end

  // One cycle per write that touches a translation-related field.
  always_ff @(posedge clk) begin
    if (!rstN) flushPulse <= 1'b0;
    else       flushPulse <= strb.doWrite & diffHit;
  end

endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  msrStrobe_t      strb,
  input  logic [XLEN-1:0] wrData,
  input  logic            specNew,
  output logic [XLEN-1:0] statusQ,
  output logic [XLEN-1:0] supView,
  output logic            diffHit
);

  localparam int TopBit = XLEN - 1;
  localparam logic [XLEN-1:0] SdMask = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [63:0] ExtW = (XLEN == 64) ? WrExt64  : 64'h0;
  localparam logic [63:0] ExtF = (XLEN == 64) ? FlVirt64 : 64'h0;
  localparam logic [XLEN-1:0] WrNew  = XLEN'(WrBase | WrTrapCtl | ExtW);
  localparam logic [XLEN-1:0] WrOld  = XLEN'(WrBase);
  localparam logic [XLEN-1:0] VmMask = XLEN'(VmField);
  localparam logic [XLEN-1:0] FlNew  = XLEN'(FlBase | ExtF);
  localparam logic [XLEN-1:0] FlOld  = XLEN'(FlBase | VmField);
  localparam logic [XLEN-1:0] SupOld = XLEN'(SupBase) | SdMask;
  localparam logic [XLEN-1:0] SupNew = SupOld | XLEN'(MxrBit);

  logic [XLEN-1:0] supMask, merged, wrMask, flMask, written, nextVal;
  logic [VmW-1:0]  vmReq;
  logic            vmOk;

  assign vmReq = merged[VmLo +: VmW];

  // Supported translation modes differ by register width.
  generate
    if (XLEN == 64) begin : g_vm64
      assign vmOk = (vmReq == 5'd0) || (vmReq == 5'd9) || (vmReq == 5'd10);
    end else begin : g_vm32
      assign vmOk = (vmReq == 5'd0) || (vmReq == 5'd8);
    end
  endgenerate

  always_comb begin
    supMask = specNew ? SupNew : SupOld;
    merged  = strb.viaSup ? ((statusQ & ~supMask) | (wrData & supMask)) : wrData;
    wrMask  = specNew ? WrNew : (WrOld | (vmOk ? VmMask : '0));
    flMask  = specNew ? FlNew : FlOld;
    diffHit = |((merged ^ statusQ) & flMask);
    written = (statusQ & ~wrMask) | (merged & wrMask);

    nextVal = strb.doWrite ? written : statusQ;
    if (strb.markFp) nextVal[FsLo +: 2] = 2'b11;
    if (strb.doWrite || strb.markFp)
      nextVal[TopBit] = (&nextVal[FsLo +: 2]) | (&nextVal[XsLo +: 2]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= RST_VAL[XLEN-1:0];
    else       statusQ <= nextVal;
  end

  assign supView = statusQ & supMask;

endmodule

// File: rtl/msr_status_reg.sv
module msr_status_reg
  import msr_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWrEn,
  input  logic            csrSupSel,
  input  logic [XLEN-1:0] csrWrData,
  input  logic            specNew,
  input  logic            fpDirtySet,
  output logic [XLEN-1:0] statusOut,
  output logic [XLEN-1:0] supViewOut,
  output logic            tlbFlush
);

  msrStrobe_t strb;
  logic       diffHit;

  msr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .csrWrEn    (csrWrEn),
    .csrSupSel  (csrSupSel),
    .fpDirtySet (fpDirtySet),
    .diffHit    (diffHit),
    .strb       (strb),
    .flushPulse (tlbFlush)
  );

  msr_datapath #(.XLEN(XLEN), .RST_VAL(RST_VAL)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (csrWrData),
    .specNew (specNew),
    .statusQ (statusOut),
    .supView (supViewOut),
    .diffHit (diffHit)
  );

endmodule

// File: rtl/msr_status_chk.sv
module msr_status_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrWrEn,
  input logic            csrSupSel,
  input logic            fpDirtySet,
  input logic [XLEN-1:0] statusOut,
  input logic            tlbFlush
);

  // R6: summary bit consistent after any update
  a_r6_sd_tracks: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn || fpDirtySet) |=> statusOut[XLEN-1] ==
      ((&statusOut[14:13]) || (&statusOut[16:15])));

  // R10: dirty strobe lands
  a_r10_fp_dirty: assert property (@(posedge clk) disable iff (!rstN)
    fpDirtySet |=> ((&statusOut[14:13]) && statusOut[XLEN-1]));

  // R7: a flush only follows a write
  a_r7_flush_src: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> $past(csrWrEn));

  // R11: idle holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!csrWrEn && !fpDirtySet) |=> ($stable(statusOut) && !tlbFlush));

  // R9: supervisor writes keep machine-only fields
  a_r9_sup_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrSupSel) |=>
      ($stable(statusOut[12:11]) && $stable(statusOut[3]) && $stable(statusOut[7])));

  // R2: extension state is never written
  a_r2_xs_fixed: assert property (@(posedge clk) disable iff (!rstN)
    $stable(statusOut[16:15]));

endmodule

bind msr_status_reg msr_status_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .csrWrEn    (csrWrEn),
  .csrSupSel  (csrSupSel),
  .fpDirtySet (fpDirtySet),
  .statusOut  (statusOut),
  .tlbFlush   (tlbFlush)
);

// File: tb/msr_status_reg_tb_top.sv
module msr_status_reg_tb_top;

  localparam logic [63:0] WMN  = 64'h0000_00C0_007E_79AA;
  localparam logic [63:0] WMO  = 64'h0000_0000_000E_79AA;
  localparam logic [63:0] VMM  = 64'h0000_0000_1F00_0000;
  localparam logic [63:0] FLN  = 64'h0000_0080_000E_1800;
  localparam logic [63:0] FLO  = 64'h0000_0000_1F0E_1800;
  localparam logic [63:0] SUPO = 64'h8000_0000_0005_E133;
  localparam logic [63:0] SUPN = 64'h8000_0000_000D_E133;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, supSel = 1'b0, spec = 1'b1, fpSet = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] stat, sview, xsStat, xsView;
  logic flush, xsFlush;

  always #5 clk = ~clk;

  msr_status_reg #(.XLEN(64)) dut_i (
    .clk(clk), .rstN(rstN), .csrWrEn(wrEn), .csrSupSel(supSel),
    .csrWrData(wrData), .specNew(spec), .fpDirtySet(fpSet),
    .statusOut(stat), .supViewOut(sview), .tlbFlush(flush));

  // Second instance: extension state dirty out of reset.
  msr_status_reg #(.XLEN(64), .RST_VAL(64'h8000_0000_0001_8000)) xsDut_i (
    .clk(clk), .rstN(rstN), .csrWrEn(wrEn), .csrSupSel(supSel),
    .csrWrData(wrData), .specNew(spec), .fpDirtySet(fpSet),
    .statusOut(xsStat), .supViewOut(xsView), .tlbFlush(xsFlush));

  typedef struct {
    logic [63:0] st;
    logic [63:0] sv;
    logic        fl;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errs = 0;
  logic [63:0] mdl = '0;

  task automatic op(input bit wr, input bit sup, input bit fp, input bit sp,
                    input logic [63:0] d, input string tag);
    logic [63:0] m, wm, fm, sm, n;
    logic [4:0] vm;
    bit fl;
    item_t it;
    @(negedge clk);
    wrEn = wr; supSel = sup; fpSet = fp; spec = sp; wrData = d;
    sm = sp ? SUPN : SUPO;
    m  = sup ? ((mdl & ~sm) | (d & sm)) : d;
    vm = m[28:24];
    wm = sp ? WMN : (WMO | ((vm == 5'd0 || vm == 5'd9 || vm == 5'd10) ? VMM : 64'h0));
    fm = sp ? FLN : FLO;
    n = mdl; fl = 1'b0;
    if (wr) begin
      n  = (mdl & ~wm) | (m & wm);
      fl = ((m ^ mdl) & fm) != 64'h0;
    end
    if (fp) n[14:13] = 2'b11;
    if (wr || fp) n[63] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    mdl = n;
    it.st = n; it.sv = n & sm; it.fl = fl; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare one expected item per clock, away from the edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (stat !== e.st || sview !== e.sv || flush !== e.fl) begin
        errs++;
        $display("FAIL %s: status=%h view=%h flush=%b expected status=%h view=%h flush=%b",
                 e.tag, stat, sview, flush, e.st, e.sv, e.fl);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (stat !== 64'h0 || flush !== 1'b0) begin
      errs++;
      $display("FAIL R1 in reset: status=%h flush=%b expected 0 0", stat, flush);
    end
    rstN = 1'b1;
    op(0, 0, 0, 1, 64'h0, "R1 after reset");
    // R2, R4, R6, R7: full write in newer set
    op(1, 0, 0, 1, '1, "R2 R4 R6 R7 all-ones");
    op(1, 0, 0, 1, '1, "R7 same value no flush");
    op(0, 0, 0, 1, 64'h0, "R11 idle hold");
    op(1, 0, 0, 1, 64'h0, "R6 clear summary");
    op(1, 0, 0, 1, 64'h8000_0000_0001_8601, "R2 R6 ignored bits");
    // R3, R5: older set
    op(1, 0, 0, 0, '1, "R3 R5 older invalid mode");
    op(1, 0, 0, 0, 64'h0000_0000_0970_0000, "R3 R5 older mode 9");
    op(1, 0, 0, 0, 64'h0000_0080_0970_0000, "R7 older ignores bit39");
    op(1, 0, 0, 1, 64'h0000_0000_0900_0000, "R3 newer trap bits");
    op(1, 0, 0, 1, 64'h0000_0080_0900_0000, "R4 R7 newer bit39 flush");
    // R8, R9: supervisor path
    op(1, 0, 0, 1, 64'h0000_0000_0000_1888, "R9 machine setup");
    op(1, 1, 0, 1, '1, "R8 R9 sup all-ones");
    op(1, 1, 0, 0, 64'h0, "R8 R9 sup clear older");
    op(0, 0, 0, 1, 64'h0, "R8 view newer");
    // R10: dirty strobe
    op(0, 0, 1, 1, 64'h0, "R10 fp dirty alone");
    op(1, 0, 0, 1, 64'h0, "R6 clear again");
    op(1, 0, 1, 1, 64'h0, "R10 fp with clearing write");
    op(1, 0, 0, 0, 64'h0000_0000_0800_0000, "R5 R7 older mode 8 rejected");
    op(0, 0, 0, 1, 64'h0, "R11 R7 idle after flush");
    op(0, 0, 0, 1, 64'h0, "R11 idle");
    @(negedge clk);
    // R6: extension-dirty instance keeps summary set
    checks++;
    if (xsStat[63] !== 1'b1 || xsStat[16:15] !== 2'b11) begin
      errs++;
      $display("FAIL R6 xs path: top=%b xs=%b expected 1 11", xsStat[63], xsStat[16:15]);
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule